// File: doc/BRIEF.md
# Dual-Modulus Synthesizer Divider Chain

This block holds the digital counting path of an integer-N frequency synthesizer. A reference divider turns reference-clock events into a comparison pulse. A feedback divider turns oscillator-clock events into a feedback pulse. It is built from a 32/33 prescaler model, a main counter and a swallow counter, so the total feedback ratio is 32 times the main count plus the swallow count. A digital phase-frequency detector compares the two pulse trains and produces up and down requests. A lock monitor watches how long those requests last in each comparison cycle. A small test selector decides what drives the single lock-detect pin.

The block runs on one fast system clock. The reference and oscillator clocks arrive as single-cycle event strobes (`ref_en`, `vco_en`), one per rising edge of the clock they stand for. Divider settings arrive already decoded from a register interface. Each counter samples them only when its own cycle ends, so a write never produces a shortened or stretched period.

Top module: `synth_div_chain`

## Requirements
- R1: The reference divider emits one `cmp_pulse` every R events of `ref_en`, with R chosen by `ref_sel`: 00 gives 3, 01 gives 4, 10 gives 6, 11 gives 8. System clock cycles without `ref_en` are not counted.
- R2: The feedback divider emits one `fb_pulse` every 32·M + S events of `vco_en`. M is chosen by `main_sel` (00 gives 32, 01 gives 33, 10 gives 34, 11 gives 35). S is the binary value of `swallow`, from 0 to 31.
- R3: A change of `ref_sel`, `main_sel` or `swallow` during a divider period leaves that period's length unchanged. The new value applies from the next period on.
- R4: After reset, the first `ref_en` event produces a `cmp_pulse` and the first `vco_en` event produces a `fb_pulse`, each visible on the clock after the event. Every pulse lasts exactly one clock.
- R5: `pd_up` goes high the clock after `cmp_pulse` and `pd_dn` goes high the clock after `fb_pulse`. Whichever is high is cleared at the end of the clock that shows the opposite pulse. Coincident pulses raise neither output, and the two are never high together.
- R6: In each comparison cycle, the number of clocks in which an up or down request was active is counted, up to and including the closing `cmp_pulse`. `lock` rises on the clock after the 16th consecutive `cmp_pulse` whose count is below `lock_thr`. It falls on the clock after any `cmp_pulse` whose count is at or above `lock_thr`.
- R7: `ld_pin` is chosen by `tmux_sel`. 00 gives `lock`. 01 gives the count of comparison pulses since reset, modulo 2. 10 gives the count of feedback pulses since reset, modulo 2. 11 gives bit 8 of the comparison pulse count, which is the comparison rate divided by 512. Each value changes on the same clock as the pulse that advances it.
- R8: `cp_hiz` follows `cp_float_req` one clock later. While `cp_hiz` is 1, `pd_up` and `pd_dn` are held at 0, but the detector keeps its state, so the requests reappear when `cp_hiz` returns to 0.
- R9: During and right after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | Reference clock event strobe |
| vco_en | input | 1 | Oscillator clock event strobe |
| ref_sel | input | 2 | Reference ratio code |
| main_sel | input | 2 | Main counter ratio code |
| swallow | input | SW_W | Swallow count |
| lock_thr | input | PW_W | Request-width limit for a good comparison cycle |
| tmux_sel | input | 2 | Lock-detect pin source select |
| cp_float_req | input | 1 | Request charge pump high impedance |
| cmp_pulse | output | 1 | Comparison pulse from the reference divider |
| fb_pulse | output | 1 | Feedback pulse from the programmable divider |
| pd_up | output | 1 | Pump-up request |
| pd_dn | output | 1 | Pump-down request |
| cp_hiz | output | 1 | Charge pump high-impedance control |
| lock | output | 1 | Lock indication |
| ld_pin | output | 1 | Lock-detect pin value |

## Verification
A wrong count in either divider shows as a feedback or comparison interval off by the error. The bench sees this within one period of the affected divider, about 1,151 oscillator events at the longest ratio. A swallow counter that fails to stop at zero shifts the interval by exactly the missing or extra 33-event prescaler cycles, so each swallow value checked gives a distinct expected interval. Detector or lock-counter state faults show at the next comparison pulse as a request width that differs from the injected phase offset, or as `lock` moving one pulse early or late. A toggle or divide-by-512 fault shows on `ld_pin` at the first comparison pulse that advances it.

// File: rtl/synth_div_chain.sv
module synth_div_chain #(
  parameter int PRE_LOG2    = 5,
  parameter int SW_W        = 5,
  parameter int PW_W        = 8,
  parameter int LOCK_CYCLES = 16,
  parameter int SLOW_LOG2   = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_en,
  input  logic            vco_en,
  input  logic [1:0]      ref_sel,
  input  logic [1:0]      main_sel,
  input  logic [SW_W-1:0] swallow,
  input  logic [PW_W-1:0] lock_thr,
  input  logic [1:0]      tmux_sel,
  input  logic            cp_float_req,
  output logic            cmp_pulse,
  output logic            fb_pulse,
  output logic            pd_up,
  output logic            pd_dn,
  output logic            cp_hiz,
  output logic            lock,
  output logic            ld_pin
);

  localparam int PRE_MOD = 1 << PRE_LOG2;
  localparam int PC_W    = $clog2(PRE_MOD + 1);
  localparam int MC_W    = $clog2(PRE_MOD + 4);
  localparam int LK_W    = $clog2(LOCK_CYCLES + 1);

  function automatic logic [2:0] ref_last(input logic [1:0] code);
    case (code)
      2'b00:   ref_last = 3'd2;
      2'b01:   ref_last = 3'd3;
      2'b10:   ref_last = 3'd5;
      default: ref_last = 3'd7;
    endcase
  endfunction

  // reference divider
  logic [2:0] rcnt;
  logic       ref_tc;
  assign ref_tc = ref_en && (rcnt == 3'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      rcnt <= '0;
    else if (ref_en) rcnt <= (rcnt == 3'd0) ? ref_last(ref_sel) : rcnt - 3'd1;

  // prescaler, main and swallow counters
  logic [PC_W-1:0] pcnt;
  logic [MC_W-1:0] mcnt;
  logic [SW_W-1:0] scnt, s_next;
  logic            pre_tc, fb_tc;

  assign pre_tc = vco_en && (pcnt == '0);
  assign fb_tc  = pre_tc && (mcnt == '0);

  always_comb
    if (mcnt == '0)       s_next = swallow;
    else if (scnt != '0)  s_next = scnt - 1'b1;
    else                  s_next = '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pcnt <= '0;
      mcnt <= '0;
      scnt <= '0;
    end else if (pre_tc) begin
      scnt <= s_next;
      mcnt <= (mcnt == '0) ? MC_W'(PRE_MOD - 1) + MC_W'(main_sel) : mcnt - 1'b1;
      pcnt <= (s_next != '0) ? PC_W'(PRE_MOD) : PC_W'(PRE_MOD - 1);
    end else if (vco_en) begin
      pcnt <= pcnt - 1'b1;
    end

  // pulses, phase-frequency detector, pump float
  logic up_q, dn_q, up_n, dn_n;
  assign up_n = up_q | cmp_pulse;
  assign dn_n = dn_q | fb_pulse;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp_pulse <= 1'b0;
      fb_pulse  <= 1'b0;
      up_q      <= 1'b0;
      dn_q      <= 1'b0;
      cp_hiz    <= 1'b0;
    end else begin
      cmp_pulse <= ref_tc;
      fb_pulse  <= fb_tc;
      up_q      <= up_n & ~dn_n;
      dn_q      <= dn_n & ~up_n;
      cp_hiz    <= cp_float_req;
    end

  assign pd_up = up_q & ~cp_hiz;
  assign pd_dn = dn_q & ~cp_hiz;

  // lock monitor
  logic [PW_W-1:0] wcnt;
  logic [PW_W:0]   meas;
  logic [LK_W-1:0] gcnt;
  logic            active, good;

  assign active = up_q | dn_q;
  assign meas   = {1'b0, wcnt} + {{PW_W{1'b0}}, active};
  assign good   = meas < {1'b0, lock_thr};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wcnt <= '0;
      gcnt <= '0;
      lock <= 1'b0;
    end else if (cmp_pulse) begin
      wcnt <= '0;
      if (!good) begin
        gcnt <= '0;
        lock <= 1'b0;
      end else if (gcnt == LK_W'(LOCK_CYCLES - 1)) begin
        lock <= 1'b1;
      end else begin
        gcnt <= gcnt + 1'b1;
      end
    end else if (active && wcnt != {PW_W{1'b1}}) begin
      wcnt <= wcnt + 1'b1;
    end

  // test selector
  logic [SLOW_LOG2-1:0] ncnt;
  logic                 fb_t;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ncnt <= '0;
      fb_t <= 1'b0;
    end else begin
      if (ref_tc) ncnt <= ncnt + 1'b1;
      if (fb_tc)  fb_t <= ~fb_t;
    end

  always_comb
    case (tmux_sel)
      2'b00:   ld_pin = lock;
      2'b01:   ld_pin = ncnt[0];
      2'b10:   ld_pin = fb_t;
      default: ld_pin = ncnt[SLOW_LOG2-1];
    endcase

endmodule

// File: rtl/synth_div_chain_chk.sv
module synth_div_chain_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmp_pulse,
  input logic       fb_pulse,
  input logic       pd_up,
  input logic       pd_dn,
  input logic       cp_hiz,
  input logic       lock,
  input logic [1:0] tmux_sel,
  input logic       ld_pin
);

  p_cmp_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |=> !cmp_pulse);

  p_fb_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  p_pd_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pd_up && pd_dn));

  p_up_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pd_up) && !$past(cp_hiz)) |-> $past(cmp_pulse));

  p_lock_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(cmp_pulse));

  p_lock_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> $past(cmp_pulse));

  p_div2_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmux_sel == 2'b01 && $past(tmux_sel) == 2'b01 && !cmp_pulse) |-> $stable(ld_pin));

endmodule

bind synth_div_chain synth_div_chain_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_pulse (cmp_pulse),
  .fb_pulse  (fb_pulse),
  .pd_up     (pd_up),
  .pd_dn     (pd_dn),
  .cp_hiz    (cp_hiz),
  .lock      (lock),
  .tmux_sel  (tmux_sel),
  .ld_pin    (ld_pin)
);

// File: tb/tb_synth_div_chain.sv
module tb_synth_div_chain;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b0, vco_en = 1'b0;
  logic [1:0] ref_sel = 2'b00, main_sel = 2'b00, tmux_sel = 2'b00;
  logic [4:0] swallow = 5'd0;
  logic [7:0] lock_thr = 8'd4;
  logic       cp_float_req = 1'b0;
  logic       cmp_pulse, fb_pulse, pd_up, pd_dn, cp_hiz, lock, ld_pin;

  int checks = 0, failures = 0;
  int n_cmp = 0, n_fb = 0, up_hi = 0, dn_hi = 0;
  int rc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  synth_div_chain dut (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .vco_en(vco_en),
    .ref_sel(ref_sel), .main_sel(main_sel), .swallow(swallow),
    .lock_thr(lock_thr), .tmux_sel(tmux_sel), .cp_float_req(cp_float_req),
    .cmp_pulse(cmp_pulse), .fb_pulse(fb_pulse), .pd_up(pd_up), .pd_dn(pd_dn),
    .cp_hiz(cp_hiz), .lock(lock), .ld_pin(ld_pin)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic v);
    ref_en = r;
    vco_en = v;
    @(posedge clk);
    @(negedge clk);
    ref_en = 1'b0;
    vco_en = 1'b0;
    if (cmp_pulse) n_cmp++;
    if (fb_pulse)  n_fb++;
    if (pd_up)     up_hi++;
    if (pd_dn)     dn_hi++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    n_cmp = 0; n_fb = 0; up_hi = 0; dn_hi = 0; rc = 0;
  endtask

  task automatic wait_fb(output int n);
    n = 0;
    do begin step(1'b0, 1'b1); n++; end while (!fb_pulse);
  endtask

  task automatic wait_cmp(input int gap, output int n);
    bit got;
    n = 0;
    do begin
      step(1'b1, 1'b0); n++; got = cmp_pulse;
      repeat (gap) step(1'b0, 1'b0);
    end while (!got);
  endtask

  task automatic run_cycle();
    bit r;
    r = (rc == 0);
    step(r, 1'b1);
    rc = r ? 127 : rc - 1;
  endtask

  task automatic run_to_cmp();
    do run_cycle(); while (!cmp_pulse);
  endtask

  function automatic int ref_ratio(input int c);
    case (c)
      0: return 3;
      1: return 4;
      2: return 6;
      default: return 8;
    endcase
  endfunction

  initial begin
    int n, d, mism;
    int sw_list[4] = '{0, 1, 16, 31};

    do_reset();
    // R9 reset state
    check({cmp_pulse, fb_pulse, pd_up, pd_dn, cp_hiz, lock, ld_pin} == 7'b0,
          "R9 outputs after reset", {cmp_pulse, fb_pulse, pd_up, pd_dn, cp_hiz, lock, ld_pin}, 0);

    // R4 first events
    step(1'b0, 1'b1);
    check(fb_pulse == 1'b1, "R4 first vco event pulse", fb_pulse, 1);
    step(1'b0, 1'b1);
    check(fb_pulse == 1'b0, "R4 fb pulse one clock", fb_pulse, 0);
    step(1'b1, 1'b0);
    check(cmp_pulse == 1'b1, "R4 first ref event pulse", cmp_pulse, 1);
    step(1'b0, 1'b0);
    check(cmp_pulse == 1'b0, "R4 cmp pulse one clock", cmp_pulse, 0);

    // R2 feedback ratio sweep
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 4; k++) begin
        main_sel = 2'(m);
        swallow  = 5'(sw_list[k]);
        wait_fb(d);
        wait_fb(n);
        check(n == 32 * (32 + m) + sw_list[k], "R2 feedback interval", n, 32 * (32 + m) + sw_list[k]);
      end
    end

    // R3 mid-period change, feedback
    main_sel = 2'b00; swallow = 5'd0;
    wait_fb(d);
    wait_fb(d);
    repeat (10) step(1'b0, 1'b1);
    main_sel = 2'b11; swallow = 5'd31;
    wait_fb(n);
    check(n + 10 == 1024, "R3 feedback period in progress", n + 10, 1024);
    wait_fb(n);
    check(n == 1151, "R3 feedback new period", n, 1151);

    // R1 reference ratios
    for (int c = 0; c < 4; c++) begin
      ref_sel = 2'(c);
      wait_cmp(0, d);
      wait_cmp(0, n);
      check(n == ref_ratio(c), "R1 reference interval", n, ref_ratio(c));
    end
    ref_sel = 2'b10;
    wait_cmp(2, d);
    wait_cmp(2, n);
    check(n == 6, "R1 idle clocks not counted", n, 6);

    // R3 mid-period change, reference
    ref_sel = 2'b00;
    wait_cmp(0, d);
    wait_cmp(0, d);
    step(1'b1, 1'b0);
    ref_sel = 2'b11;
    wait_cmp(0, n);
    check(n + 1 == 3, "R3 reference period in progress", n + 1, 3);
    wait_cmp(0, n);
    check(n == 8, "R3 reference new period", n, 8);

    // R5 R6 R8 lock scenario: cmp and fb both every 1024 clocks
    ref_sel = 2'b11; main_sel = 2'b00; swallow = 5'd0; lock_thr = 8'd4; tmux_sel = 2'b00;
    do_reset();
    while (n_cmp < 16) run_to_cmp();
    check(lock == 1'b0, "R6 no lock at 16th pulse", lock, 0);
    run_cycle();
    check(lock == 1'b1, "R6 lock after 16th pulse", lock, 1);
    while (n_cmp < 20) run_to_cmp();
    check(up_hi + dn_hi == 0, "R5 aligned pulses no request", up_hi + dn_hi, 0);

    rc += 3;
    run_to_cmp();
    up_hi = 0; dn_hi = 0;
    run_to_cmp();
    check(dn_hi == 3 && up_hi == 0, "R5 lag three gives down width", dn_hi * 100 + up_hi, 300);
    run_cycle();
    check(lock == 1'b1, "R6 width below limit keeps lock", lock, 1);

    cp_float_req = 1'b1;
    run_cycle();
    check(cp_hiz == 1'b1, "R8 float follows request", cp_hiz, 1);
    up_hi = 0; dn_hi = 0;
    run_to_cmp();
    check(dn_hi + up_hi == 0, "R8 requests held low", dn_hi + up_hi, 0);
    cp_float_req = 1'b0;
    run_cycle();
    check(cp_hiz == 1'b0, "R8 float released", cp_hiz, 0);
    up_hi = 0; dn_hi = 0;
    run_to_cmp();
    check(dn_hi == 3, "R8 detector state kept", dn_hi, 3);
    check(ld_pin == 1'b1, "R7 pin shows lock", ld_pin, 1);

    rc += 3;
    run_to_cmp();
    check(lock == 1'b1, "R6 lock held on failing pulse", lock, 1);
    run_cycle();
    check(lock == 1'b0, "R6 lock drops after wide request", lock, 0);
    check(ld_pin == 1'b0, "R7 pin shows unlock", ld_pin, 0);

    // R7 reference divided by 2 and by 512
    ref_sel = 2'b00; tmux_sel = 2'b01;
    do_reset();
    mism = 0;
    for (int i = 0; i < 200; i++) begin
      step(1'b1, 1'b0);
      if (ld_pin != 1'(n_cmp & 1)) mism++;
    end
    check(mism == 0, "R7 reference half rate", mism, 0);
    tmux_sel = 2'b11;
    mism = 0;
    for (int i = 0; i < 1500; i++) begin
      step(1'b1, 1'b0);
      if (ld_pin != 1'((n_cmp >> 8) & 1)) mism++;
    end
    check(mism == 0 && n_cmp > 512, "R7 reference over 512", mism, 0);

    // R7 feedback divided by 2
    tmux_sel = 2'b10; main_sel = 2'b00; swallow = 5'd0;
    do_reset();
    mism = 0;
    for (int i = 0; i < 3100; i++) begin
      step(1'b0, 1'b1);
      if (ld_pin != 1'(n_fb & 1)) mism++;
    end
    check(mism == 0 && n_fb == 4, "R7 feedback half rate", mism, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule